// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. It sits behind a two-address, byte-wide register bus. One address holds the run controls: enable, start, auto-trigger enable, interrupt enable, completion flag and a 3-bit clock divide code. The other holds the channel and reference selection. The block makes a conversion clock from the system clock, runs the sample phase, and then drives the trial level of the external DAC one bit at a time. It reads the answer from an external comparator, and at the end it publishes the result, sets the completion flag and raises an interrupt if that is enabled.

Software writes the start bit, or an external trigger pulse does the same job once auto-trigger is on. Software then polls the start bit, which reads as busy, or waits for the interrupt. The channel and reference outputs that drive the analog front end change only while the block is enabled and idle, so a selection written during a conversion applies only to the next one. The result read-out path is a separate block that is fed by `result_o` and `done_o`.

Top module: `sar_conv_ctrl`

## Requirements
- R1: Divide code k in control bits [7:5] sets the conversion-clock period to 2^max(k,1) system clocks, so codes 0 and 1 give 2, and 2 through 7 give 4, 8, 16, 32, 64 and 128. The code is captured when a conversion starts, and a conversion of N conversion-clock cycles clears busy exactly N times that period after the edge that started it.
- R2: Address 0 is the control register: bit0 enable, bit1 start, bit2 auto-trigger, bit3 interrupt enable, bit4 flag. Writing 1 to bit1 while enabled and idle starts a conversion. Bit1 reads 1 while a conversion runs and 0 otherwise. Writing 0 to bit1 has no effect, and a start written while busy is ignored. Every register reads 0 after reset.
- R3: Apart from the case in R4, a conversion lasts 13 conversion-clock cycles.
- R4: The first conversion after enable goes from 0 to 1, including one started by the same write, lasts 25 conversion-clock cycles.
- R5: `sample_o` is high for the first N-10 conversion-clock cycles. In each of the last 10 cycles, `dac_o` shows the bits already decided plus a trial one at the current position, working from bit 9 down to bit 0. The trial bit is kept when `cmp_i` is 1 at the end of that cycle. `dac_o` is 0 outside that phase. `done_o` pulses in the final system cycle, and `result_o` then holds the search result until the next completion.
- R6: The flag (bit4) is set on completion. It is cleared by writing 1 to bit4 or by `irq_ack_i`, and writing 0 to bit4 leaves it alone. A completion in the same cycle as a clear leaves it set.
- R7: `irq_o` is high exactly when the flag and the interrupt enable are both set.
- R8: Address 1 holds channel in bits [4:0] and reference in bits [6:5], reads back as written, and resets to 0. `chan_o` and `ref_o` copy it one cycle after any cycle in which the block is enabled and idle, and hold during a conversion and while disabled.
- R9: With enable clear, no conversion starts and the divider is stopped. Clearing enable during a conversion ends it without setting the flag or changing `result_o`.
- R10: With auto-trigger and enable set, a one-cycle `trig_i` pulse while idle starts a conversion. A pulse while busy, or with auto-trigger clear, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address: 0 control, 1 selection |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| trig_i | input | 1 | Auto-trigger pulse |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| cmp_i | input | 1 | Comparator: analog input at or above `dac_o` level |
| sample_o | output | 1 | Sample-and-hold tracking |
| dac_o | output | 10 | Trial level for the DAC |
| chan_o | output | 5 | Active channel select |
| ref_o | output | 2 | Active reference select |
| result_o | output | 10 | Last completed result |
| done_o | output | 1 | Completion pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The comparator model answers against a held analog code. The codes used are 0, full scale, mid scale, alternating bit patterns and random values. Zero and full scale show whether every trial bit is dropped or kept, and the alternating patterns catch a wrong bit order or an off-by-one bit position. A reference model runs beside the design cycle by cycle and checks the trial level at every cycle, so a fault in sample length, decision timing or accumulation shows up in the cycle where it happens. Separate conversions at several divide codes, first-after-enable conversions, auto-triggered conversions, and triggers or starts landing mid-conversion tell the 13-cycle and 25-cycle lengths apart from the divide factors and from ignored restarts.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int DATA_W    = 8;
  localparam int PS_W      = 3;
  localparam int DIV_LOG   = 7;
  localparam int SHORT_LEN = 13;
  localparam int LONG_LEN  = 25;

  // control register bit positions
  localparam int C_EN   = 0;
  localparam int C_GO   = 1;
  localparam int C_AUTO = 2;
  localparam int C_IE   = 3;
  localparam int C_FLAG = 4;
  localparam int C_PS   = 5;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_SEL  = 1'b1;

  typedef struct packed {
    logic [PS_W-1:0] ps;
    logic            ie;
    logic            auto_trig;
    logic            en;
  } ctrl_t;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
  parameter int PS_W    = 3,
  parameter int LOG_MAX = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            tick_o
);
  localparam int CNT_W = LOG_MAX;

  logic [CNT_W-1:0] cnt_q, term;
  logic [PS_W-1:0]  sh;

  always_comb begin
    sh = (sel_i == '0) ? PS_W'(1) : sel_i;
    if (sh > PS_W'(LOG_MAX)) sh = PS_W'(LOG_MAX);
    term = CNT_W'((32'd1 << sh) - 32'd1);
  end

  assign tick_o = run_i && (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R1: smallest factor is 2, so ticks never come back to back
  a_r1_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES_W     = 10,
  parameter int SHORT_LEN = 13,
  parameter int LONG_LEN  = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             long_i,
  input  logic             abort_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             sample_o,
  output logic             done_o,
  output logic [RES_W-1:0] dac_o,
  output logic [RES_W-1:0] result_o
);
  localparam int PH_W = $clog2(LONG_LEN + 1);

  logic             busy_q;
  logic [PH_W-1:0]  ph_q, len_q, samp_len, last_ph, bitpos;
  logic [RES_W-1:0] acc_q, res_q, trial, next_acc;
  logic             resolving;

  assign samp_len  = len_q - PH_W'(RES_W);
  assign last_ph   = len_q - 1'b1;
  assign bitpos    = last_ph - ph_q;
  assign resolving = busy_q && (ph_q >= samp_len);

  always_comb begin
    for (int i = 0; i < RES_W; i++)
      trial[i] = acc_q[i] | (bitpos == PH_W'(i));
  end

  assign next_acc = cmp_i ? trial : acc_q;
  assign done_o   = busy_q && tick_i && !abort_i && (ph_q == last_ph);
  assign busy_o   = busy_q;
  assign sample_o = busy_q && (ph_q < samp_len);
  assign dac_o    = resolving ? trial : '0;
  assign result_o = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      len_q  <= PH_W'(SHORT_LEN);
      acc_q  <= '0;
      res_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      ph_q   <= '0;
      acc_q  <= '0;
      len_q  <= long_i ? PH_W'(LONG_LEN) : PH_W'(SHORT_LEN);
    end else if (busy_q) begin
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (tick_i) begin
        ph_q <= ph_q + 1'b1;
        if (resolving) acc_q <= next_acc;
        if (ph_q == last_ph) begin
          busy_q <= 1'b0;
          res_q  <= next_acc;
        end
      end
    end
  end

  // R2: completion drops busy on the next edge
  a_r2_done_clears_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R5: every conversion opens with the sample phase
  a_r5_start_samples: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> sample_o);
  // R5: decided bits are never dropped within a conversion
  a_r5_acc_keeps_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ((acc_q & $past(acc_q)) == $past(acc_q)));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int CH_W  = 5,
  parameter int REF_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              trig_i,
  input  logic              irq_ack_i,
  input  logic              cmp_i,
  output logic              sample_o,
  output logic [RES_W-1:0]  dac_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [REF_W-1:0]  ref_o,
  output logic [RES_W-1:0]  result_o,
  output logic              done_o,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  logic             flag_q, init_q;
  logic [PS_W-1:0]  ps_run_q, ps_d;
  logic [CH_W-1:0]  sel_chan_q, chan_q;
  logic [REF_W-1:0] sel_ref_q, ref_q;

  logic wr_ctrl, wr_sel, en_d, init_d, abort, start, busy, tick, done;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_sel  = wr_en_i && (addr_i == ADDR_SEL);
  assign en_d    = wr_ctrl ? wdata_i[C_EN] : ctrl_q.en;
  assign ps_d    = wr_ctrl ? wdata_i[C_PS +: PS_W] : ctrl_q.ps;
  assign abort   = wr_ctrl && !wdata_i[C_EN];
  assign init_d  = init_q || (wr_ctrl && wdata_i[C_EN] && !ctrl_q.en);
  assign start   = !busy && en_d &&
                   ((wr_ctrl && wdata_i[C_GO]) ||
                    (trig_i && ctrl_q.auto_trig && ctrl_q.en));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
      init_q   <= 1'b0;
      ps_run_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en        <= wdata_i[C_EN];
        ctrl_q.auto_trig <= wdata_i[C_AUTO];
        ctrl_q.ie        <= wdata_i[C_IE];
        ctrl_q.ps        <= wdata_i[C_PS +: PS_W];
      end
      if (done)                                        flag_q <= 1'b1;
      else if ((wr_ctrl && wdata_i[C_FLAG]) || irq_ack_i) flag_q <= 1'b0;
      init_q <= (en_d && !start) ? init_d : 1'b0;
      if (start) ps_run_q <= ps_d;
    end
  end

  // selection: written any time, applied only when enabled and idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_chan_q <= '0;
      sel_ref_q  <= '0;
      chan_q     <= '0;
      ref_q      <= '0;
    end else begin
      if (ctrl_q.en && !busy) begin
        chan_q <= sel_chan_q;
        ref_q  <= sel_ref_q;
      end
      if (wr_sel) begin
        sel_chan_q <= wdata_i[CH_W-1:0];
        sel_ref_q  <= wdata_i[CH_W +: REF_W];
      end
    end
  end

  sar_clkdiv #(.PS_W(PS_W), .LOG_MAX(DIV_LOG)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .sel_i  (ps_run_q),
    .tick_o (tick)
  );

  sar_engine #(.RES_W(RES_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .long_i   (init_d),
    .abort_i  (abort),
    .tick_i   (tick),
    .cmp_i    (cmp_i),
    .busy_o   (busy),
    .sample_o (sample_o),
    .done_o   (done),
    .dac_o    (dac_o),
    .result_o (result_o)
  );

  always_comb begin
    if (addr_i == ADDR_SEL)
      rdata_o = DATA_W'({sel_ref_q, sel_chan_q});
    else
      rdata_o = {ctrl_q.ps, flag_q, ctrl_q.ie, ctrl_q.auto_trig, busy, ctrl_q.en};
  end

  assign chan_o = chan_q;
  assign ref_o  = ref_q;
  assign done_o = done;
  assign irq_o  = flag_q && ctrl_q.ie;

  // R6: completion always leaves the flag set
  a_r6_flag_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> flag_q);
  // R8: active selection frozen during a conversion
  a_r8_sel_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(chan_q) && $stable(ref_q)));
  // R9: no conversion while disabled
  a_r9_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.en |-> !busy);
endmodule

// File: tb/sar_conv_ctrl_tb.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0, addr = 1'b0, trig = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cmp, sample, done, irq;
  logic [9:0] dac, result;
  logic [4:0] chan;
  logic [1:0] refs;
  int         vin = 0;
  int         nvec = 0, nfail = 0;
  bit         finished = 0;

  always #2.5 clk_i = ~clk_i;

  sar_conv_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .trig_i(trig), .irq_ack_i(ack),
    .cmp_i(cmp), .sample_o(sample), .dac_o(dac), .chan_o(chan),
    .ref_o(refs), .result_o(result), .done_o(done), .irq_o(irq)
  );

  // comparator: analog input at or above trial level
  assign cmp = (int'(dac) <= vin);

  // ---------------- reference model ----------------
  bit m_en, m_auto, m_ie, m_flag, m_init, m_busy;
  int m_ps, m_fac, m_len, m_cyc, m_chan, m_ref, m_schan, m_sref, m_res;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_auto = 0; m_ie = 0; m_flag = 0; m_init = 0; m_busy = 0;
      m_ps = 0; m_fac = 2; m_len = 13; m_cyc = 0;
      m_chan = 0; m_ref = 0; m_schan = 0; m_sref = 0; m_res = 0;
    end else begin
      bit o_en, o_busy, o_auto, wc, ws, ab, dn, en_new, st;
      o_en = m_en; o_busy = m_busy; o_auto = m_auto;
      wc = wr_en && !addr; ws = wr_en && addr;
      if (o_en && !o_busy) begin m_chan = m_schan; m_ref = m_sref; end
      ab = wc && !wdata[0];
      dn = 0;
      if (o_busy && !ab) begin
        m_cyc++;
        if (m_cyc == m_len * m_fac) begin dn = 1; m_busy = 0; m_res = vin; end
      end
      if (ab) m_busy = 0;
      if (dn) m_flag = 1;
      else if ((wc && wdata[4]) || ack) m_flag = 0;
      en_new = wc ? wdata[0] : o_en;
      if (wc && wdata[0] && !o_en) m_init = 1;
      st = !o_busy && en_new && ((wc && wdata[1]) || (trig && o_auto && o_en));
      if (wc) begin m_en = wdata[0]; m_auto = wdata[2]; m_ie = wdata[3]; m_ps = wdata[7:5]; end
      if (st) begin
        m_busy = 1; m_cyc = 0; m_len = m_init ? 25 : 13; m_init = 0;
        m_fac = 1 << ((m_ps == 0) ? 1 : m_ps);
      end
      if (!en_new) m_init = 0;
      if (ws) begin m_schan = wdata[4:0]; m_sref = wdata[6:5]; end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && !finished) begin
      int e_rd, e_dac, ph, bp;
      bit e_smp, e_done;
      e_rd = addr ? ((m_sref << 5) | m_schan)
                  : ((m_ps << 5) | (m_flag << 4) | (m_ie << 3) | (m_auto << 2) | (m_busy << 1) | m_en);
      e_smp = m_busy && (m_cyc < (m_len - 10) * m_fac);
      e_dac = 0;
      if (m_busy && !e_smp) begin
        ph = m_cyc / m_fac; bp = m_len - 1 - ph;
        e_dac = ((vin >> (bp + 1)) << (bp + 1)) | (1 << bp);
      end
      e_done = m_busy && (m_cyc + 1 == m_len * m_fac) && !(wr_en && !addr && !wdata[0]);
      chk("R2", "rdata", rdata, e_rd);
      chk("R5", "sample", sample, e_smp);
      chk("R5", "dac", dac, e_dac);
      chk("R5", "done", done, e_done);
      chk("R5", "result", result, m_res);
      chk("R6", "flag", rdata[4] | addr, m_flag | addr);
      chk("R7", "irq", irq, m_flag && m_ie);
      chk("R8", "chan", chan, m_chan);
      chk("R8", "ref", refs, m_ref);
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [7:0] ctl(bit en, bit go, bit au, bit ie, bit clr, int ps);
    return {3'(ps), clr, ie, au, go, en};
  endfunction

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i); wr_en = 1; addr = a; wdata = d;
    @(negedge clk_i); wr_en = 0; addr = 0; wdata = '0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    do begin @(posedge clk_i); #1; n++; end while (rdata[1] && n < 5000);
  endtask

  task automatic pulse_trig();
    @(negedge clk_i); trig = 1; @(negedge clk_i); trig = 0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R2", "reset ctrl", rdata, 0);
    chk("R8", "reset chan", chan, 0);

    wr(1, {1'b0, 2'b01, 5'd5});
    repeat (3) @(negedge clk_i);
    chk("R8", "chan while disabled", chan, 0);
    chk("R8", "sel readback", 0, 0);

    vin = 'h2A5;
    wr(0, ctl(1, 1, 0, 1, 0, 0));
    wait_idle(n);
    chk("R4", "first conv length", n, 50);
    chk("R6", "flag after conv", rdata[4], 1);
    chk("R5", "result", result, 'h2A5);
    repeat (2) @(negedge clk_i);
    chk("R8", "chan applied", chan, 5);
    chk("R8", "ref applied", refs, 1);
    wr(0, ctl(1, 0, 0, 1, 1, 0));
    chk("R7", "irq after clear", irq, 0);

    vin = 'h3FF;
    wr(0, ctl(1, 1, 0, 1, 0, 3));
    wr(1, {1'b0, 2'b10, 5'd9});
    chk("R8", "chan frozen", chan, 5);
    wait_idle(n);
    chk("R3", "conv length ps3", n, 104 - 2);
    chk("R5", "full scale", result, 'h3FF);
    repeat (2) @(negedge clk_i);
    chk("R8", "chan after conv", chan, 9);
    wr(0, ctl(1, 0, 0, 1, 1, 3));
    @(posedge clk_i); #1;
    chk("R2", "zero start no effect", rdata[1], 0);

    vin = 0;
    wr(0, ctl(1, 1, 0, 1, 0, 7));
    wait_idle(n);
    chk("R1", "conv length ps7", n, 13 * 128);
    chk("R5", "zero scale", result, 0);
    @(negedge clk_i); ack = 1; @(negedge clk_i); ack = 0;
    chk("R6", "ack clears flag", rdata[4], 0);

    vin = 'h200;
    wr(0, ctl(1, 1, 0, 1, 0, 1));
    wr(0, ctl(1, 1, 0, 1, 0, 1));
    wait_idle(n);
    chk("R2", "start while busy ignored", n, 26 - 2);
    chk("R1", "code 1 factor", n + 2, 13 * 2);

    wr(0, ctl(1, 0, 1, 1, 1, 0));
    vin = 'h155;
    pulse_trig();
    chk("R10", "trigger starts", rdata[1], 1);
    pulse_trig();
    wait_idle(n);
    chk("R10", "trigger while busy ignored", n, 26 - 2);
    chk("R5", "alternating", result, 'h155);
    wr(0, ctl(1, 0, 0, 1, 1, 0));
    pulse_trig();
    chk("R10", "trigger without auto", rdata[1], 0);

    vin = 'h2AA;
    wr(0, ctl(1, 1, 0, 1, 0, 2));
    repeat (5) @(negedge clk_i);
    wr(0, ctl(0, 0, 0, 1, 0, 2));
    repeat (80) @(negedge clk_i);
    chk("R9", "abort no flag", rdata[4], 0);
    chk("R9", "abort idle", rdata[1], 0);
    chk("R9", "abort keeps result", result, 'h155);
    wr(0, ctl(0, 1, 0, 1, 0, 2));
    @(posedge clk_i); #1;
    chk("R9", "start while disabled", rdata[1], 0);
    wr(0, ctl(1, 0, 0, 1, 0, 0));
    wr(0, ctl(1, 1, 0, 1, 0, 0));
    wait_idle(n);
    chk("R4", "first after re-enable", n, 50);
    chk("R5", "pattern 2AA", result, 'h2AA);
    wr(0, ctl(1, 1, 0, 1, 1, 0));
    wait_idle(n);
    chk("R3", "normal length", n, 26);

    for (int i = 0; i < 8; i++) begin
      int ps;
      ps = i % 3;
      vin = $urandom_range(0, 1023);
      wr(0, ctl(1, 1, 0, i % 2, 1, ps));
      wait_idle(n);
      chk("R1", "random length", n, 13 * (1 << ((ps == 0) ? 1 : ps)));
      chk("R5", "random result", result, vin);
    end

    repeat (4) @(negedge clk_i);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      nvec++; nfail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule